// File: doc/BRIEF.md
# Paged RAM Address Translator with Page Status Tracking

The block turns a 22-bit logical RAM address into a physical RAM address through a page map held inside the block. The address splits into a 10-bit page index and a 12-bit byte offset. The index selects one of 1024 map entries. Each entry gives a 10-bit physical page number, a page write-enable bit and a two-bit page status. The status is encoded as `ps[1:0]`, where `ps[1]` is the high bit. The value 00 means the page is not mapped in. The physical address is the page number followed by the unchanged offset.

Every accepted access also performs a read-modify-write of the page status in the same cycle. The next status depends on three things: the current status, whether the access is a write, and whether the caller marked the access as faulting.

The physical address is then routed to one of three regions:
- a base RAM region below 0x200000, which wraps at its size;
- an expansion RAM region from 0x200000, which is bounded by its size;
- an empty region for expansion addresses beyond the fitted size, where reads return all ones.

Software or a controller loads the map through a separate byte-enabled write port. All access results are registered and appear one cycle after the access.

Top module: `pt_xlate`

## Requirements
- R1: An access presented with `acc_valid` high produces `out_valid` high exactly one clock later. In that cycle `phys_addr` equals the page number of the entry selected by `acc_addr[21:12]`, followed by `acc_addr[11:0]` unchanged.
- R2: A map write updates the entry at `map_idx` only in the bytes whose `map_be` bit is set. The entry layout is:
  - bit 15: page write enable;
  - bit 14: `ps[1]`;
  - bit 13: `ps[0]`;
  - bits 12:10: unused;
  - bits 9:0: physical page number.
- R3: On an access without `acc_fault`, the new status has `ps[1]` set.
- R4: On an access without `acc_fault`, the new `ps[0]` is 1 in two cases: the old status is 01 or 10 and the access is a write, or the old status is 11. Otherwise the new `ps[0]` is 0. `st_before` reports the old status and `st_after` the new one.
- R5: On an access with `acc_fault` high, the stored status is left unchanged (`st_after` equals `st_before`) and `wr_en` stays low.
- R6: The updated status is written back to the map, so the next access to the same page reports it in `st_before`, including when the accesses come in back-to-back cycles.
- R7: A physical address below 0x200000 selects region code 1 (base). `ram_addr` is the physical address modulo `BASE_BYTES`. A write to an address at or above `BASE_BYTES` is discarded (`wr_en` low).
- R8: A physical address from 0x200000 upward has offset (phys − 0x200000).
  - If the offset is below `EXP_BYTES`, the region code is 2 (expansion), `ram_addr` is the offset and writes are allowed.
  - Otherwise the region code is 0 (empty, reads as all ones) and `wr_en` is low.
- R9: When a map write and an access hit the same entry in the same cycle, the map write wins for the bytes it enables. The access's status update survives only if the high byte is not enabled.
- R10: After reset, `out_valid`, `wr_en` and `region` are 0 until an access arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access accepted this cycle |
| acc_addr | input | 22 | Logical RAM address |
| acc_write | input | 1 | Access is a write |
| acc_fault | input | 1 | Access faulted; freeze page status |
| map_we | input | 1 | Map entry write strobe |
| map_idx | input | 10 | Map entry index |
| map_be | input | 2 | Byte enables for the entry write |
| map_wdata | input | 16 | Entry write data |
| out_valid | output | 1 | Result registers hold a new access |
| phys_addr | output | 22 | Translated physical address |
| region | output | 2 | 0 empty, 1 base, 2 expansion |
| ram_addr | output | 21 | Byte address inside the selected region |
| wr_en | output | 1 | Write may be carried out |
| page_wr_ok | output | 1 | Write-enable bit of the accessed entry |
| st_before | output | 2 | Page status before the access |
| st_after | output | 2 | Page status after the access |

## Verification
The bench drives every old-status and direction pair through the status rule. A design that mixes up the 01 and 10 write cases, or that drops the 11-holds case, would leave `ps[0]` wrong.

It checks a faulting write, which must neither touch the status nor enable the write. It also runs back-to-back accesses, where a missing write-back or a stale read would show the old status.

On the routing side, it probes base addresses above the base size. A wrong mask would break the wrap there, and a missing bound would let the write through. Expansion addresses past the fitted size must fall into the empty region.

Finally, it collides map writes with accesses to the same entry, using each byte-enable pattern. This exposes a wrong precedence, which would either lose the map data or lose the status update.

// File: rtl/pt_pkg.sv
package pt_pkg;

  localparam int ENT_W   = 16;
  localparam int WE_BIT  = 15;
  localparam int PS1_BIT = 14;
  localparam int PS0_BIT = 13;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_BASE = 2'd1,
    RGN_EXP  = 2'd2
  } region_e;

endpackage

// File: rtl/pt_map_store.sv
module pt_map_store #(
  parameter int IDX_W = 10,
  parameter int ENT_W = 16
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_ent,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [1:0]       upd_ps,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [ENT_W/8-1:0] cfg_be,
  input  logic [ENT_W-1:0] cfg_wdata
);
  import pt_pkg::*;

  localparam int ENTRIES = 1 << IDX_W;
  localparam int NBYTES  = ENT_W / 8;

  logic [ENT_W-1:0] mem [ENTRIES];

  // Asynchronous read so the status read-modify-write fits in one cycle.
  assign rd_ent = mem[rd_idx];

  // Status update first, configuration bytes afterwards: the map port
  // overrides the bytes it enables when both hit one entry.
  always_ff @(posedge clk) begin
    if (upd_en) begin
      mem[upd_idx][PS1_BIT:PS0_BIT] <= upd_ps;
    end
    for (int b = 0; b < NBYTES; b++) begin
      if (cfg_we && cfg_be[b]) begin
        mem[cfg_idx][b*8 +: 8] <= cfg_wdata[b*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/pt_state_step.sv
module pt_state_step (
  input  logic [1:0] ps_cur,
  input  logic       is_write,
  input  logic       is_fault,
  output logic [1:0] ps_nxt
);
  logic mid_state;
  logic set_low;

  always_comb begin
    mid_state = ps_cur[1] ^ ps_cur[0];
    set_low   = (mid_state && is_write) || (ps_cur == 2'b11);
    if (is_fault) begin
      ps_nxt = ps_cur;
    end else begin
      ps_nxt = {1'b1, set_low};
    end
  end

endmodule

// File: rtl/pt_region_route.sv
module pt_region_route #(
  parameter int PHYS_W     = 22,
  parameter int BASE_BYTES = 1 << 20,
  parameter int EXP_BYTES  = 1 << 19
) (
  input  logic [PHYS_W-1:0] phys,
  input  logic              is_write,
  input  logic              is_fault,
  output logic [1:0]        rgn,
  output logic [PHYS_W-2:0] loc,
  output logic              wr_ok
);
  import pt_pkg::*;

  localparam int RAM_AW = PHYS_W - 1;
  localparam logic [31:0]       BASE_LIM  = 32'(BASE_BYTES);
  localparam logic [31:0]       EXP_LIM   = 32'(EXP_BYTES);
  localparam logic [RAM_AW-1:0] BASE_MASK = RAM_AW'(BASE_BYTES - 1);

  logic              upper;
  logic [RAM_AW-1:0] off;
  logic              in_base;
  logic              in_exp;

  always_comb begin
    upper   = phys[PHYS_W-1];
    off     = phys[RAM_AW-1:0];
    in_base = 32'(off) < BASE_LIM;
    in_exp  = 32'(off) < EXP_LIM;
    rgn     = RGN_NONE;
    loc     = '0;
    wr_ok   = 1'b0;
    if (!upper) begin
      rgn   = RGN_BASE;
      loc   = off & BASE_MASK;
      wr_ok = is_write && !is_fault && in_base;
    end else if (in_exp) begin
      rgn   = RGN_EXP;
      loc   = off;
      wr_ok = is_write && !is_fault;
    end
  end

endmodule

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int LADDR_W    = 22,
  parameter int OFS_W      = 12,
  parameter int PPN_W      = 10,
  parameter int BASE_BYTES = 1 << 20,
  parameter int EXP_BYTES  = 1 << 19
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      acc_valid,
  input  logic [LADDR_W-1:0]        acc_addr,
  input  logic                      acc_write,
  input  logic                      acc_fault,
  input  logic                      map_we,
  input  logic [LADDR_W-OFS_W-1:0]  map_idx,
  input  logic [1:0]                map_be,
  input  logic [15:0]               map_wdata,
  output logic                      out_valid,
  output logic [PPN_W+OFS_W-1:0]    phys_addr,
  output logic [1:0]                region,
  output logic [PPN_W+OFS_W-2:0]    ram_addr,
  output logic                      wr_en,
  output logic                      page_wr_ok,
  output logic [1:0]                st_before,
  output logic [1:0]                st_after
);
  import pt_pkg::*;

  localparam int IDX_W  = LADDR_W - OFS_W;
  localparam int PHYS_W = PPN_W + OFS_W;

  logic [IDX_W-1:0]  idx;
  logic [ENT_W-1:0]  ent;
  logic [1:0]        ps_cur;
  logic [1:0]        ps_nxt;
  logic [PHYS_W-1:0] phys;
  logic [1:0]        rgn_c;
  logic [PHYS_W-2:0] loc_c;
  logic              wr_ok_c;

  assign idx    = acc_addr[LADDR_W-1:OFS_W];
  assign ps_cur = ent[PS1_BIT:PS0_BIT];
  assign phys   = {ent[PPN_W-1:0], acc_addr[OFS_W-1:0]};

  pt_map_store #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_store (
    .clk       (clk),
    .rd_idx    (idx),
    .rd_ent    (ent),
    .upd_en    (acc_valid && !acc_fault),
    .upd_idx   (idx),
    .upd_ps    (ps_nxt),
    .cfg_we    (map_we),
    .cfg_idx   (map_idx),
    .cfg_be    (map_be),
    .cfg_wdata (map_wdata)
  );

  pt_state_step u_step (
    .ps_cur   (ps_cur),
    .is_write (acc_write),
    .is_fault (acc_fault),
    .ps_nxt   (ps_nxt)
  );

  pt_region_route #(
    .PHYS_W(PHYS_W), .BASE_BYTES(BASE_BYTES), .EXP_BYTES(EXP_BYTES)
  ) u_route (
    .phys     (phys),
    .is_write (acc_write),
    .is_fault (acc_fault),
    .rgn      (rgn_c),
    .loc      (loc_c),
    .wr_ok    (wr_ok_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      phys_addr  <= '0;
      region     <= RGN_NONE;
      ram_addr   <= '0;
      wr_en      <= 1'b0;
      page_wr_ok <= 1'b0;
      st_before  <= 2'b00;
      st_after   <= 2'b00;
    end else begin
      out_valid <= acc_valid;
      wr_en     <= acc_valid && wr_ok_c;
      if (acc_valid) begin
        phys_addr  <= phys;
        region     <= rgn_c;
        ram_addr   <= loc_c;
        page_wr_ok <= ent[WE_BIT];
        st_before  <= ps_cur;
        st_after   <= ps_nxt;
      end
    end
  end

endmodule

// File: rtl/pt_xlate_chk.sv
module pt_xlate_chk #(
  parameter int LADDR_W    = 22,
  parameter int OFS_W      = 12,
  parameter int PPN_W      = 10,
  parameter int BASE_BYTES = 1 << 20
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   acc_valid,
  input logic [LADDR_W-1:0]     acc_addr,
  input logic                   acc_fault,
  input logic                   out_valid,
  input logic [PPN_W+OFS_W-1:0] phys_addr,
  input logic [1:0]             region,
  input logic [PPN_W+OFS_W-2:0] ram_addr,
  input logic                   wr_en,
  input logic [1:0]             st_before,
  input logic [1:0]             st_after
);

  assert_valid_lat_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(acc_valid));

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> phys_addr[OFS_W-1:0] == $past(acc_addr[OFS_W-1:0]));

  assert_ps1_set_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(acc_fault)) |-> st_after[1]);

  assert_full_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(acc_fault) && st_before == 2'b11) |-> st_after == 2'b11);

  assert_fault_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(acc_fault)) |-> (st_after == st_before && !wr_en));

  assert_base_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && region == 2'd1) |-> 32'(ram_addr) < 32'(BASE_BYTES));

  assert_empty_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
    (region == 2'd0) |-> !wr_en);

  assert_reset_idle_R10: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !wr_en));

endmodule

bind pt_xlate pt_xlate_chk #(
  .LADDR_W(LADDR_W), .OFS_W(OFS_W), .PPN_W(PPN_W), .BASE_BYTES(BASE_BYTES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_addr  (acc_addr),
  .acc_fault (acc_fault),
  .out_valid (out_valid),
  .phys_addr (phys_addr),
  .region    (region),
  .ram_addr  (ram_addr),
  .wr_en     (wr_en),
  .st_before (st_before),
  .st_after  (st_after)
);

// File: tb/pt_xlate_test.sv
module pt_xlate_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [21:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_fault = 1'b0;
  logic        map_we = 1'b0;
  logic [9:0]  map_idx = '0;
  logic [1:0]  map_be = '0;
  logic [15:0] map_wdata = '0;
  logic        out_valid;
  logic [21:0] phys_addr;
  logic [1:0]  region;
  logic [20:0] ram_addr;
  logic        wr_en;
  logic        page_wr_ok;
  logic [1:0]  st_before;
  logic [1:0]  st_after;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pt_xlate uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_fault(acc_fault), .map_we(map_we),
    .map_idx(map_idx), .map_be(map_be), .map_wdata(map_wdata),
    .out_valid(out_valid), .phys_addr(phys_addr), .region(region),
    .ram_addr(ram_addr), .wr_en(wr_en), .page_wr_ok(page_wr_ok),
    .st_before(st_before), .st_after(st_after)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] entry(input logic we, input logic [1:0] ps, input logic [9:0] ppn);
    return {we, ps, 3'b000, ppn};
  endfunction

  task automatic map_set(input logic [9:0] idx, input logic [15:0] data, input logic [1:0] be);
    @(negedge clk);
    map_we = 1'b1; map_idx = idx; map_wdata = data; map_be = be;
    @(negedge clk);
    map_we = 1'b0; map_be = 2'b00;
  endtask

  task automatic access(input logic [21:0] a, input logic wr, input logic flt);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = wr; acc_fault = flt;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_fault = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 out_valid", 32'(out_valid), 0);
    check("R10 wr_en", 32'(wr_en), 0);
    check("R10 region", 32'(region), 0);
  endtask

  task automatic t_translate;
    map_set(10'h003, entry(1'b1, 2'b10, 10'h005), 2'b11);
    access(22'h003ABC, 1'b0, 1'b0);
    check("R1 valid", 32'(out_valid), 1);
    check("R1 phys", 32'(phys_addr), 32'h005ABC);
    check("R2 we bit", 32'(page_wr_ok), 1);
    map_set(10'h3FF, entry(1'b0, 2'b10, 10'h0C7), 2'b11);
    access(22'h3FF001, 1'b0, 1'b0);
    check("R1 phys top page", 32'(phys_addr), 32'h0C7001);
    check("R2 we bit clear", 32'(page_wr_ok), 0);
    @(negedge clk);
    check("R1 valid drops", 32'(out_valid), 0);
  endtask

  task automatic t_status_rule;
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 2; w++) begin
        logic [1:0] exp;
        exp = {1'b1, ((w == 1) && (s == 1 || s == 2)) || (s == 3)};
        map_set(10'h00A, entry(1'b1, 2'(s), 10'h001), 2'b11);
        access(22'h00A010, 1'(w), 1'b0);
        check("R4 st_before", 32'(st_before), 32'(s));
        check("R3 R4 st_after", 32'(st_after), 32'(exp));
      end
    end
  endtask

  task automatic t_fault;
    map_set(10'h00B, entry(1'b1, 2'b01, 10'h002), 2'b11);
    access(22'h00B000, 1'b1, 1'b1);
    check("R5 status frozen", 32'(st_after), 32'h1);
    check("R5 no write", 32'(wr_en), 0);
    access(22'h00B000, 1'b0, 1'b0);
    check("R5 stored unchanged", 32'(st_before), 32'h1);
  endtask

  task automatic t_back_to_back;
    map_set(10'h00C, entry(1'b1, 2'b00, 10'h003), 2'b11);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 22'h00C004; acc_write = 1'b0;
    @(negedge clk);
    check("R6 first after", 32'(st_after), 32'h2);
    acc_write = 1'b1;
    @(negedge clk);
    check("R6 second sees 10", 32'(st_before), 32'h2);
    check("R6 second after", 32'(st_after), 32'h3);
    acc_write = 1'b0;
    @(negedge clk);
    check("R6 third sees 11", 32'(st_before), 32'h3);
    acc_valid = 1'b0;
  endtask

  task automatic t_base;
    access(22'h003100, 1'b1, 1'b0);
    check("R7 base region", 32'(region), 1);
    check("R7 base ram_addr", 32'(ram_addr), 32'h005100);
    check("R7 base write ok", 32'(wr_en), 1);
    map_set(10'h020, entry(1'b1, 2'b10, 10'h150), 2'b11);
    access(22'h020123, 1'b0, 1'b0);
    check("R7 wrap region", 32'(region), 1);
    check("R7 wrap addr", 32'(ram_addr), 32'h050123);
    access(22'h020123, 1'b1, 1'b0);
    check("R7 write past base dropped", 32'(wr_en), 0);
  endtask

  task automatic t_expansion;
    map_set(10'h021, entry(1'b1, 2'b10, 10'h210), 2'b11);
    access(22'h021456, 1'b1, 1'b0);
    check("R8 exp region", 32'(region), 2);
    check("R8 exp addr", 32'(ram_addr), 32'h010456);
    check("R8 exp write", 32'(wr_en), 1);
    map_set(10'h022, entry(1'b1, 2'b10, 10'h290), 2'b11);
    access(22'h022789, 1'b0, 1'b0);
    check("R8 empty region", 32'(region), 0);
    access(22'h022789, 1'b1, 1'b0);
    check("R8 empty write dropped", 32'(wr_en), 0);
  endtask

  task automatic t_collision;
    map_set(10'h007, entry(1'b1, 2'b00, 10'h004), 2'b11);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 22'h007000; acc_write = 1'b0;
    map_we = 1'b1; map_idx = 10'h007; map_be = 2'b10; map_wdata = entry(1'b1, 2'b01, 10'h000);
    @(negedge clk);
    acc_valid = 1'b0; map_we = 1'b0; map_be = 2'b00;
    access(22'h007000, 1'b0, 1'b0);
    check("R9 high byte wins", 32'(st_before), 32'h1);
    check("R2 low byte kept", 32'(phys_addr), 32'h004000);
    map_set(10'h008, entry(1'b1, 2'b00, 10'h004), 2'b11);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 22'h008000; acc_write = 1'b0;
    map_we = 1'b1; map_idx = 10'h008; map_be = 2'b01; map_wdata = 16'h0066;
    @(negedge clk);
    acc_valid = 1'b0; map_we = 1'b0; map_be = 2'b00;
    access(22'h008000, 1'b0, 1'b0);
    check("R9 status update kept", 32'(st_before), 32'h2);
    check("R2 low byte written", 32'(phys_addr), 32'h066000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_translate();
    t_status_rule();
    t_fault();
    t_back_to_back();
    t_base();
    t_expansion();
    t_collision();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule